// File: doc/BRIEF.md
# Power Gain and Offset Calibrator

This block is a two-stage pipelined datapath. It trims a stream of signed, already filtered active-power samples. It accepts one sample on any cycle where the input strobe is high. First it adds a programmable offset, held at 1/256 of a sample LSB, so that a residual reading can be cancelled when no power flows. Then it multiplies the corrected value by a programmable gain of the form one plus a signed fraction of 4096. The result is rounded back to sample resolution and clamped to the signed output range. It leaves the block with a valid strobe two cycles after the sample went in.

Calibration software writes the two coefficients through a one-word write port. A select bit chooses the coefficient. Each sample takes a snapshot of both coefficients in the cycle it is accepted, so no sample ever combines an old coefficient with a new one.

Top module: `pwrcal_top`

## Requirements
- R1: After reset, out_vld is 0, out_pwr is 0 and both coefficients are 0. Until the first write, every sample passes through unchanged.
- R2: For each cycle with in_vld high, out_vld is high for exactly one cycle, two cycles later. Back-to-back samples give back-to-back results in the same order.
- R3: With gain 0 and offset 0, out_pwr equals in_pwr for every input, including the most positive and most negative codes.
- R4: A write with cfg_sel=0 loads cfg_data[11:0] as a signed gain g. The result is in_pwr×(4096+g)/4096, so 0x7FF scales by 6143/4096 (about +50%) and 0x800 scales by exactly one half.
- R5: A write with cfg_sel=1 loads cfg_data[15:0] as a signed offset o in units of 1/256 LSB (0x0100 is one LSB). The offset is added before the gain is applied: result = (in_pwr + o/256)×(4096+g)/4096.
- R6: The exact result is rounded to the nearest integer, and a tie (fraction exactly one half) rounds toward positive infinity.
- R7: A result above 2^23−1 gives 0x7FFFFF and a result below −2^23 gives 0x800000. The output never wraps.
- R8: A write in cycle t applies to samples presented in later cycles. A sample presented in the same cycle as a write uses the old coefficients. With cfg_we low, cfg_sel and cfg_data have no effect.
- R9: While no result is being delivered, out_vld stays 0 and out_pwr holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample strobe |
| in_pwr | input | 24 | Signed input power sample |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 1 | 0 selects gain, 1 selects offset |
| cfg_data | input | 16 | Coefficient value (gain uses bits 11:0) |
| out_vld | output | 1 | Calibrated sample strobe |
| out_pwr | output | 24 | Signed calibrated power sample |

## Verification
The embedded properties check on every cycle:
- the two-cycle strobe relation;
- that the coefficients do not move without a write;
- that a positive corrected sum never produces a negative output (and the reverse), which is the no-wrap rule;
- unity pass-through when the snapshot gain is zero;
- that the output holds between results.

The exact values under each gain and offset need the bench's directed scenarios:
- the tie-breaking direction of rounding;
- the order of offset and gain;
- the clamp codes;
- the same-cycle write ordering.

// File: rtl/pwrcal_pkg.sv
package pwrcal_pkg;
  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_GAIN_W   = 12;
  localparam int DEF_OFS_W    = 16;
  localparam int DEF_OFS_FRAC = 8;

  typedef enum logic {
    SEL_GAIN = 1'b0,
    SEL_OFS  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/pwrcal_coef.sv
module pwrcal_coef
  import pwrcal_pkg::*;
#(
  parameter int GAIN_W = DEF_GAIN_W,
  parameter int OFS_W  = DEF_OFS_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [OFS_W-1:0]         cfg_data,
  output logic signed [GAIN_W-1:0] gain_q,
  output logic signed [OFS_W-1:0]  ofs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      ofs_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_GAIN) gain_q <= cfg_data[GAIN_W-1:0];
      else                     ofs_q  <= cfg_data;
    end
  end

  // R8: coefficients only move on a write
  assert_coef_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(gain_q) && $stable(ofs_q)));
endmodule

// File: rtl/pwrcal_offset_stage.sv
module pwrcal_offset_stage
  import pwrcal_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int OFS_W    = DEF_OFS_W,
  parameter int OFS_FRAC = DEF_OFS_FRAC,
  localparam int SUM_W   = SAMPLE_W + OFS_FRAC + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic signed [SAMPLE_W-1:0] in_pwr,
  input  logic signed [GAIN_W-1:0]   gain_q,
  input  logic signed [OFS_W-1:0]    ofs_q,
  output logic                       s1_vld,
  output logic signed [SUM_W-1:0]    s1_sum,
  output logic signed [GAIN_W-1:0]   s1_gain
);
  logic signed [SUM_W-1:0] sum_d;

  always_comb begin
    sum_d = (SUM_W'(in_pwr) <<< OFS_FRAC) + SUM_W'(ofs_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_sum  <= '0;
      s1_gain <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_sum  <= sum_d;
        s1_gain <= gain_q;
      end
    end
  end

  // R2: every accepted sample enters the first stage
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> s1_vld);
endmodule

// File: rtl/pwrcal_scale_stage.sv
module pwrcal_scale_stage
  import pwrcal_pkg::*;
#(
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int GAIN_W    = DEF_GAIN_W,
  parameter int OFS_FRAC  = DEF_OFS_FRAC,
  localparam int SUM_W    = SAMPLE_W + OFS_FRAC + 1,
  localparam int FAC_W    = GAIN_W + 2,
  localparam int PROD_W   = SUM_W + FAC_W,
  localparam int SHIFT    = OFS_FRAC + GAIN_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       s1_vld,
  input  logic signed [SUM_W-1:0]    s1_sum,
  input  logic signed [GAIN_W-1:0]   s1_gain,
  output logic                       out_vld,
  output logic signed [SAMPLE_W-1:0] out_pwr
);
  localparam logic signed [PROD_W-1:0] HALF =
    {{(PROD_W-1){1'b0}}, 1'b1} << (SHIFT - 1);
  localparam logic signed [PROD_W-1:0] SAT_MAX =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] SAT_MIN =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [FAC_W-1:0]    factor;
  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   rounded;
  logic signed [SAMPLE_W-1:0] clamped;

  always_comb begin
    factor  = $signed({2'b01, {GAIN_W{1'b0}}}) + $signed({{2{s1_gain[GAIN_W-1]}}, s1_gain});
    prod    = PROD_W'(s1_sum) * PROD_W'(factor);
    rounded = (prod + HALF) >>> SHIFT;
    if (rounded > SAT_MAX)      clamped = SAT_MAX[SAMPLE_W-1:0];
    else if (rounded < SAT_MIN) clamped = SAT_MIN[SAMPLE_W-1:0];
    else                        clamped = rounded[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_pwr <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) out_pwr <= clamped;
    end
  end

  // R7: positive factor, so the sign of the sum survives (no wrap)
  assert_no_wrap_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_sum[SUM_W-1]) |=> !out_pwr[SAMPLE_W-1]);
  assert_no_wrap_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_sum[SUM_W-1]) |=> (out_pwr[SAMPLE_W-1] || out_pwr == '0));
  // R3: zero gain and whole-LSB sum in range pass the integer part unchanged
  assert_unity_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_gain == '0 && s1_sum[OFS_FRAC-1:0] == '0 &&
     s1_sum[SUM_W-1] == s1_sum[SUM_W-2])
    |=> out_pwr == $past(s1_sum[SUM_W-2:OFS_FRAC]));
  // R9: output holds between results
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> ($stable(out_pwr) && !out_vld));
endmodule

// File: rtl/pwrcal_top.sv
module pwrcal_top
  import pwrcal_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int OFS_W    = DEF_OFS_W,
  parameter int OFS_FRAC = DEF_OFS_FRAC,
  localparam int SUM_W   = SAMPLE_W + OFS_FRAC + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic signed [SAMPLE_W-1:0] in_pwr,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [OFS_W-1:0]           cfg_data,
  output logic                       out_vld,
  output logic signed [SAMPLE_W-1:0] out_pwr
);
  logic signed [GAIN_W-1:0] gain_q;
  logic signed [OFS_W-1:0]  ofs_q;
  logic                     s1_vld;
  logic signed [SUM_W-1:0]  s1_sum;
  logic signed [GAIN_W-1:0] s1_gain;

  pwrcal_coef #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) coef_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .gain_q(gain_q), .ofs_q(ofs_q));

  pwrcal_offset_stage #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W),
                        .OFS_FRAC(OFS_FRAC)) ofs_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_pwr(in_pwr),
    .gain_q(gain_q), .ofs_q(ofs_q),
    .s1_vld(s1_vld), .s1_sum(s1_sum), .s1_gain(s1_gain));

  pwrcal_scale_stage #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W),
                       .OFS_FRAC(OFS_FRAC)) scl_i (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_sum(s1_sum),
    .s1_gain(s1_gain), .out_vld(out_vld), .out_pwr(out_pwr));

  // R2: strobe passes the second stage one cycle later, both ways
  assert_latency_hi_R2: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_vld);
  assert_latency_lo_R2: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> !out_vld);
endmodule

// File: tb/pwrcal_tb_top.sv
module pwrcal_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint SMAX = 64'sd8388607;
  localparam longint SMIN = -64'sd8388608;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_vld = 1'b0;
  logic signed [23:0] in_pwr = '0;
  logic               cfg_we = 1'b0;
  logic               cfg_sel = 1'b0;
  logic [15:0]        cfg_data = '0;
  logic               out_vld;
  logic signed [23:0] out_pwr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint cur_g = 0;
  longint cur_o = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrcal_top dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_pwr(in_pwr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_vld(out_vld), .out_pwr(out_pwr));

  function automatic longint floor_div(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  // (in + o/256) * (4096+g)/4096, nearest with ties up, then clamped
  function automatic longint model(input longint pin, input longint g, input longint o);
    longint num;
    longint r;
    num = (pin * 256 + o) * (4096 + g);
    r = floor_div(num + 64'sd524288, 64'sd1048576);
    if (r > SMAX) r = SMAX;
    if (r < SMIN) r = SMIN;
    return r;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic write_cfg(input bit sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) cur_o = longint'($signed(val));
    else     cur_g = longint'($signed(val[11:0]));
  endtask

  task automatic one(input string tag, input longint pin);
    longint exp;
    exp = model(pin, cur_g, cur_o);
    @(negedge clk);
    in_vld = 1'b1; in_pwr = pin[23:0];
    @(negedge clk);
    in_vld = 1'b0;
    check({tag, " vld not early"}, longint'(out_vld), 0);
    @(negedge clk);
    check({tag, " vld"}, longint'(out_vld), 1);
    check(tag, longint'(out_pwr), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_vld after reset", longint'(out_vld), 0);
    check("R1 out_pwr after reset", longint'(out_pwr), 0);
    one("R1 zero coefficients pass", 1234);
  endtask

  task automatic t_identity();
    one("R3 negative", -5);
    one("R3 full-scale avg", 64'sh0CCCCD);
    one("R3 max code", SMAX);
    one("R3 min code", SMIN);
  endtask

  task automatic t_gain();
    write_cfg(1'b0, 16'h07FF);
    one("R4 gain 0x7FF", 4096);
    check("R4 gain 0x7FF literal", longint'(out_pwr), 6143);
    one("R4 gain 0x7FF fs avg", 64'sh0CCCCD);
    write_cfg(1'b0, 16'h0800);
    one("R4 gain 0x800 half", 4096);
    check("R4 gain 0x800 literal", longint'(out_pwr), 2048);
    write_cfg(1'b0, 16'h0001);
    one("R4 gain one LSB", 4096000);
    check("R4 gain one LSB literal", longint'(out_pwr), 4097000);
    write_cfg(1'b0, 16'h0000);
  endtask

  task automatic t_offset();
    write_cfg(1'b1, 16'h0100);
    one("R5 offset +1 LSB", 10);
    check("R5 offset +1 literal", longint'(out_pwr), 11);
    write_cfg(1'b1, 16'hFF00);
    one("R5 offset -1 LSB", 10);
    check("R5 offset -1 literal", longint'(out_pwr), 9);
    write_cfg(1'b1, 16'h0400);
    write_cfg(1'b0, 16'h0800);
    one("R5 offset before gain", 0);
    check("R5 offset before gain literal", longint'(out_pwr), 2);
    write_cfg(1'b0, 16'h0000);
    write_cfg(1'b1, 16'h0000);
  endtask

  task automatic t_round();
    write_cfg(1'b1, 16'h0080);
    one("R6 -2.5 ties up", -3);
    check("R6 -2.5 literal", longint'(out_pwr), -2);
    write_cfg(1'b1, 16'hFF80);
    one("R6 9.5 ties up", 10);
    check("R6 9.5 literal", longint'(out_pwr), 10);
    write_cfg(1'b1, 16'h0040);
    one("R6 7.25 down", 7);
    check("R6 7.25 literal", longint'(out_pwr), 7);
    write_cfg(1'b1, 16'h0000);
    write_cfg(1'b0, 16'h0800);
    one("R6 1.5 via gain", 3);
    check("R6 1.5 literal", longint'(out_pwr), 2);
    one("R6 -1.5 via gain", -3);
    check("R6 -1.5 literal", longint'(out_pwr), -1);
    write_cfg(1'b0, 16'h0000);
  endtask

  task automatic t_sat();
    write_cfg(1'b0, 16'h07FF);
    one("R7 gain clamp high", SMAX);
    check("R7 gain clamp high literal", longint'(out_pwr), SMAX);
    one("R7 gain clamp low", SMIN);
    check("R7 gain clamp low literal", longint'(out_pwr), SMIN);
    write_cfg(1'b0, 16'h0000);
    write_cfg(1'b1, 16'h7FFF);
    one("R7 offset clamp high", SMAX);
    write_cfg(1'b1, 16'h8000);
    one("R7 offset clamp low", SMIN);
    write_cfg(1'b1, 16'h0000);
  endtask

  task automatic t_stream();
    @(negedge clk); in_vld = 1'b1; in_pwr = 24'sd100;
    @(negedge clk); in_pwr = -24'sd200;
    check("R2 stream no early vld", longint'(out_vld), 0);
    @(negedge clk); in_pwr = 24'sd300;
    check("R2 stream first", longint'(out_pwr), 100);
    check("R2 stream vld1", longint'(out_vld), 1);
    @(negedge clk); in_vld = 1'b0;
    check("R2 stream second", longint'(out_pwr), -200);
    @(negedge clk);
    check("R2 stream third", longint'(out_pwr), 300);
    check("R2 stream vld3", longint'(out_vld), 1);
    @(negedge clk);
    check("R2 stream vld drops", longint'(out_vld), 0);
  endtask

  task automatic t_coef_timing();
    @(negedge clk);
    in_vld = 1'b1; in_pwr = 24'sd4096;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h0800;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    in_vld = 1'b0;
    check("R8 same-cycle write uses old gain", longint'(out_pwr), 4096);
    @(negedge clk);
    check("R8 next sample uses new gain", longint'(out_pwr), 2048);
    cur_g = -2048;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = 16'h07FF;
    @(negedge clk);
    cfg_sel = 1'b1; cfg_data = 16'h0100;
    @(negedge clk);
    one("R8 write with we low ignored", 4096);
    check("R8 ignored literal", longint'(out_pwr), 2048);
    write_cfg(1'b0, 16'h0000);
  endtask

  task automatic t_hold();
    longint last;
    one("R9 setup", 777);
    last = longint'(out_pwr);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_pwr = 24'sd555 + 24'(i);
      check("R9 hold value", longint'(out_pwr), last);
      check("R9 hold vld low", longint'(out_vld), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_identity();
    t_gain();
    t_offset();
    t_round();
    t_sat();
    t_stream();
    t_coef_timing();
    t_hold();
    repeat (2) @(negedge clk);
    report();
  end
endmodule